// File: doc/BRIEF.md
# Multi-Channel CPU Register Port

This block is the processor-facing slave port of a multi-channel serial avionics bus controller. A CPU drives a 9-bit address, active-low read and write strobes and a write data bus that is 8, 16 or 32 bits wide. The block splits the address into a channel number, a receive/transmit side, a register slot and a byte lane. It then steers the access to the control registers it holds, or to the status inputs, receive FIFO heads, transmit FIFO push ports and label memories of the channel engines around it.

Every access uses a wait handshake. The block samples a strobe on a rising clock edge and raises `wait_o`. It lowers `wait_o` when the access completes. The master keeps the strobe low while `wait_o` is high and releases it on the clock after `wait_o` falls. Register accesses finish fast. Receive data and label memory reads take six cycles, because in a full system they reach block memory. A 32-bit FIFO word crosses a narrow bus one lane at a time, and the FIFO is popped or pushed only on the access to the top lane.

Top module: `ch_regif`

## Requirements
- R1: Address bits 8:5 give the channel, bit 4 the side (0 receive, 1 transmit), bits 3:2 the slot (0 data, 1 control, 2 status, 3 label memory on the receive side and unused on the transmit side), and bits 1:0 the byte index. Each channel has an 8-bit receive control register and an 8-bit transmit control register, and each register's contents appear on `rx_ctrl`/`tx_ctrl` bits `8*ch+7 : 8*ch`.
- R2: A read of a control or status slot updates `rdata` and lowers `wait_o` on the first rising edge after the edge that samples the strobe.
- R3: A read of a receive data slot or a label memory slot updates `rdata` and lowers `wait_o` on the sixth rising edge after the sampling edge.
- R4: Every write completes, lowering `wait_o` and taking effect, on the second rising edge after the sampling edge. No FIFO or label pulse occurs at any other time.
- R5: `wait_o` rises only after an edge that sampled a strobe low. While a strobe stays low after completion, no second access starts.
- R6: The lane is the byte index shifted right by log2(DW/8), and lane k carries bits `DW*k+DW-1 : DW*k` of a 32-bit word. An 8-bit register sits in lane 0. Its other lanes read as zero, and writes to them are ignored.
- R7: Transmit data writes are staged lane by lane. Only the write to the top lane pulses the channel's `tx_push` for one cycle and presents the assembled word on `tx_word`.
- R8: Reading the top lane of a receive data slot pulses that channel's `rx_pop` for one cycle. Reading a lower lane, or writing the slot, does not.
- R9: A lane-0 label write pulses `lbl_wr` for one cycle and presents the byte on `lbl_wdata`. A lane-0 label read returns `lbl_rdata` and pulses `lbl_rd`. At most one FIFO or label pulse is high in any cycle.
- R10: The following read as zero with the control read latency and change no state: the unused transmit slot, transmit data reads, channel numbers at or above NCH, and writes to status or receive data slots.
- R11: `irq` is high exactly when any bit of `rx_irq` or `tx_irq` is high.
- R12: `rdata` changes only on the edge where a read completes.
- R13: While reset is high, `rdata`, `wait_o`, every control register and every pulse output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 9 | Channel, side, slot and byte index |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, held until the next read completes |
| wait_o | output | 1 | High while an access is in progress |
| rx_ctrl | output | NCH*8 | Receive control register of each channel |
| tx_ctrl | output | NCH*8 | Transmit control register of each channel |
| rx_status | input | NCH*8 | Receive status of each channel |
| tx_status | input | NCH*8 | Transmit status of each channel |
| rx_head | input | NCH*32 | Head word of each receive FIFO |
| rx_pop | output | NCH | Receive FIFO pop pulse |
| tx_word | output | 32 | Word to push into a transmit FIFO |
| tx_push | output | NCH | Transmit FIFO push pulse |
| lbl_wdata | output | 8 | Label byte to store |
| lbl_wr | output | NCH | Label store pulse |
| lbl_rd | output | NCH | Label read-advance pulse |
| lbl_rdata | input | NCH*8 | Current label memory output of each channel |
| rx_irq | input | NCH | Receive interrupts |
| tx_irq | input | NCH | Transmit interrupts |
| irq | output | 1 | OR of all channel interrupts |

## Verification
The checker watches several rules on every clock. It checks that the interrupt OR holds, that `wait_o` never stays high longer than the memory read latency and only rises after a sampled strobe, that read data moves only when an access completes, and that FIFO and label pulses are single, one at a time and aligned with completion. Only the bench scenarios can show that the address fields select the right register and channel. The same is true of the exact one-, two- and six-cycle latencies, the lane order of staged words, pops and pushes that fire only on the top lane, and unused slots that really leave the state alone.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int ADDR_W      = 9;
    localparam int WORD_W      = 32;
    localparam int REG_W       = 8;
    localparam int LAT_CTRL_RD = 1;
    localparam int LAT_MEM_RD  = 6;
    localparam int LAT_WR      = 2;
    localparam int CNT_W       = 3;

    typedef enum logic [1:0] {
        RS_DATA = 2'd0,
        RS_CTRL = 2'd1,
        RS_STAT = 2'd2,
        RS_LBL  = 2'd3
    } rsel_e;

    // Field order mirrors the address bits: chan[8:5] tx[4] rsel[3:2] bidx[1:0]
    typedef struct packed {
        logic [3:0] chan;
        logic       tx;
        rsel_e      rsel;
        logic [1:0] bidx;
    } cpu_addr_t;

    typedef enum logic [2:0] {
        SL_NONE, SL_CTRL, SL_STAT, SL_RXDAT, SL_TXDAT, SL_LBL
    } slot_e;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HOLD} seq_e;

    function automatic int lane_shift(input int dw);
        return (dw >= 32) ? 2 : ((dw >= 16) ? 1 : 0);
    endfunction

    function automatic slot_e slot_of(input cpu_addr_t a, input logic present, input logic rd);
        if (!present) return SL_NONE;
        case (a.rsel)
            RS_CTRL: return SL_CTRL;
            RS_STAT: return SL_STAT;
            RS_DATA: begin
                if (a.tx) return rd ? SL_NONE : SL_TXDAT;
                return rd ? SL_RXDAT : SL_NONE;
            end
            default: return a.tx ? SL_NONE : SL_LBL;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] lat_of(input slot_e s, input logic rd);
        if (!rd) return CNT_W'(LAT_WR - 1);
        if (s == SL_RXDAT || s == SL_LBL) return CNT_W'(LAT_MEM_RD - 1);
        return CNT_W'(LAT_CTRL_RD - 1);
    endfunction

endpackage

// File: rtl/regif_seq.sv
module regif_seq
    import regif_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        chan,
    output logic              tx,
    output logic [1:0]        bidx,
    output slot_e             slot,
    output logic              is_rd,
    output logic              busy,
    output logic              fire,
    output logic              start
);
    seq_e             st;
    logic [CNT_W-1:0] cnt;
    cpu_addr_t        a_in;
    logic             present;
    slot_e            s_in;

    always_comb begin
        a_in    = cpu_addr_t'(addr);
        present = (int'(a_in.chan) < NCH);
        s_in    = slot_of(a_in, present, !rd_n);
        start   = (st == ST_IDLE) && (!rd_n || !wr_n);
        busy    = (st == ST_BUSY);
        fire    = busy && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            chan  <= '0;
            tx    <= 1'b0;
            bidx  <= '0;
            slot  <= SL_NONE;
            is_rd <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st    <= ST_BUSY;
                    chan  <= a_in.chan;
                    tx    <= a_in.tx;
                    bidx  <= a_in.bidx;
                    slot  <= s_in;
                    is_rd <= !rd_n;
                    cnt   <= lat_of(s_in, !rd_n);
                end
                ST_BUSY: begin
                    if (cnt == '0) st <= ST_HOLD;
                    else cnt <= cnt - 1'b1;
                end
                ST_HOLD: if (rd_n && wr_n) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regif_ctrl_bank.sv
module regif_ctrl_bank
    import regif_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 tx,
    input  logic [3:0]           chan,
    input  logic [REG_W-1:0]     din,
    output logic [NCH*REG_W-1:0] rx_ctrl,
    output logic [NCH*REG_W-1:0] tx_ctrl
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                rx_ctrl[c*REG_W +: REG_W] <= '0;
                tx_ctrl[c*REG_W +: REG_W] <= '0;
            end else if (we && chan == 4'(c)) begin
                if (tx) tx_ctrl[c*REG_W +: REG_W] <= din;
                else    rx_ctrl[c*REG_W +: REG_W] <= din;
            end
        end
    end
endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
    import regif_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic [3:0]            chan,
    input  logic                  tx,
    input  logic [1:0]            lane,
    input  slot_e                 slot,
    input  logic [NCH*REG_W-1:0]  rx_ctrl,
    input  logic [NCH*REG_W-1:0]  tx_ctrl,
    input  logic [NCH*REG_W-1:0]  rx_status,
    input  logic [NCH*REG_W-1:0]  tx_status,
    input  logic [NCH*WORD_W-1:0] rx_head,
    input  logic [NCH*REG_W-1:0]  lbl_rdata,
    output logic [DW-1:0]         lane_data
);
    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan == 4'(c)) begin
                case (slot)
                    SL_CTRL:  word = WORD_W'(tx ? tx_ctrl[c*REG_W +: REG_W] : rx_ctrl[c*REG_W +: REG_W]);
                    SL_STAT:  word = WORD_W'(tx ? tx_status[c*REG_W +: REG_W] : rx_status[c*REG_W +: REG_W]);
                    SL_RXDAT: word = rx_head[c*WORD_W +: WORD_W];
                    SL_LBL:   word = WORD_W'(lbl_rdata[c*REG_W +: REG_W]);
                    default:  word = '0;
                endcase
            end
        end
        lane_data = word[int'(lane)*DW +: DW];
    end
endmodule

// File: rtl/ch_regif.sv
module ch_regif
    import regif_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [8:0]           addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 wait_o,
    output logic [NCH*8-1:0]     rx_ctrl,
    output logic [NCH*8-1:0]     tx_ctrl,
    input  logic [NCH*8-1:0]     rx_status,
    input  logic [NCH*8-1:0]     tx_status,
    input  logic [NCH*32-1:0]    rx_head,
    output logic [NCH-1:0]       rx_pop,
    output logic [31:0]          tx_word,
    output logic [NCH-1:0]       tx_push,
    output logic [7:0]           lbl_wdata,
    output logic [NCH-1:0]       lbl_wr,
    output logic [NCH-1:0]       lbl_rd,
    input  logic [NCH*8-1:0]     lbl_rdata,
    input  logic [NCH-1:0]       rx_irq,
    input  logic [NCH-1:0]       tx_irq,
    output logic                 irq
);
    localparam int         SH    = lane_shift(DW);
    localparam int         NLANE = 4 >> SH;
    localparam logic [1:0] MSL   = 2'(NLANE - 1);

    logic [3:0]        chan;
    logic              tx, is_rd, fire, start;
    logic [1:0]        bidx, lane;
    slot_e             slot;
    logic [DW-1:0]     wd_q, lane_data;
    logic [WORD_W-1:0] stage, stage_nxt;
    logic [NCH-1:0]    hit;
    logic              msl, ctrl_we;

    regif_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .chan(chan), .tx(tx), .bidx(bidx), .slot(slot), .is_rd(is_rd),
        .busy(wait_o), .fire(fire), .start(start)
    );

    always_comb begin
        lane = 2'(bidx >> SH);
        msl  = (lane == MSL);
        for (int c = 0; c < NCH; c++) hit[c] = (chan == 4'(c));
        ctrl_we   = fire && !is_rd && (slot == SL_CTRL) && (lane == 2'd0);
        stage_nxt = stage;
        stage_nxt[int'(lane)*DW +: DW] = wd_q;
        irq = (|rx_irq) || (|tx_irq);
    end

    regif_ctrl_bank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst(rst), .we(ctrl_we), .tx(tx), .chan(chan),
        .din(wd_q[REG_W-1:0]), .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl)
    );

    regif_rdmux #(.NCH(NCH), .DW(DW)) u_mux (
        .chan(chan), .tx(tx), .lane(lane), .slot(slot),
        .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl),
        .rx_status(rx_status), .tx_status(tx_status),
        .rx_head(rx_head), .lbl_rdata(lbl_rdata), .lane_data(lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            wd_q      <= '0;
            stage     <= '0;
            tx_word   <= '0;
            lbl_wdata <= '0;
            rx_pop    <= '0;
            tx_push   <= '0;
            lbl_wr    <= '0;
            lbl_rd    <= '0;
        end else begin
            rx_pop  <= '0;
            tx_push <= '0;
            lbl_wr  <= '0;
            lbl_rd  <= '0;
            if (start) wd_q <= wdata;
            if (fire) begin
                if (is_rd) rdata <= lane_data;
                case (slot)
                    SL_RXDAT: if (msl) rx_pop <= hit;
                    SL_TXDAT: begin
                        stage <= stage_nxt;
                        if (msl) begin
                            tx_push <= hit;
                            tx_word <= stage_nxt;
                        end
                    end
                    SL_LBL: if (lane == 2'd0) begin
                        if (is_rd) lbl_rd <= hit;
                        else begin
                            lbl_wr    <= hit;
                            lbl_wdata <= wd_q[REG_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/regif_chk.sv
module regif_chk #(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_n,
    input logic           wr_n,
    input logic           wait_o,
    input logic [DW-1:0]  rdata,
    input logic [NCH-1:0] rx_pop,
    input logic [NCH-1:0] tx_push,
    input logic [NCH-1:0] lbl_wr,
    input logic [NCH-1:0] lbl_rd,
    input logic [NCH-1:0] rx_irq,
    input logic [NCH-1:0] tx_irq,
    input logic           irq
);
    logic [3:0]         wcnt;
    logic [4*NCH-1:0]   fx;

    assign fx = {rx_pop, tx_push, lbl_wr, lbl_rd};

    always_ff @(posedge clk) begin
        if (rst) wcnt <= '0;
        else if (wait_o) wcnt <= (wcnt == 4'hF) ? wcnt : wcnt + 1'b1;
        else wcnt <= '0;
    end

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst) wcnt <= 4'd6); // R3
    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(wait_o) |-> $past(!rd_n || !wr_n)); // R5
    AST_EFFECT_AT_DONE: assert property (@(posedge clk) disable iff (rst) (|fx) |-> $fell(wait_o)); // R4
    AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst) $onehot0(fx)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !$fell(wait_o) |-> $stable(rdata)); // R12
    AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst) irq == ((|rx_irq) || (|tx_irq))); // R11
endmodule

bind ch_regif regif_chk #(.DW(DW), .NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .wait_o(wait_o),
    .rdata(rdata), .rx_pop(rx_pop), .tx_push(tx_push), .lbl_wr(lbl_wr),
    .lbl_rd(lbl_rd), .rx_irq(rx_irq), .tx_irq(tx_irq), .irq(irq)
);

// File: tb/tb_ch_regif.sv
module tb_ch_regif;
    localparam int DW  = 8;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              rd_n, wr_n;
    logic [8:0]        addr;
    logic [DW-1:0]     wdata, rdata;
    logic              wait_o, irq;
    logic [NCH*8-1:0]  rx_ctrl, tx_ctrl, rx_status, tx_status, lbl_rdata;
    logic [NCH*32-1:0] rx_head;
    logic [NCH-1:0]    rx_pop, tx_push, lbl_wr, lbl_rd, rx_irq, tx_irq;
    logic [31:0]       tx_word;
    logic [7:0]        lbl_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { int kind; int chan; logic [31:0] val; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    for (genvar c = 0; c < NCH; c++) begin : g_src
        assign rx_status[c*8 +: 8] = 8'(8'h10 + c);
        assign tx_status[c*8 +: 8] = 8'(8'h20 + c);
        assign lbl_rdata[c*8 +: 8] = 8'(8'h40 + c);
        assign rx_head[c*32 +: 32] = {8'(8'hA0 + c), 8'(8'hB0 + c), 8'(8'hC0 + c), 8'(8'hD0 + c)};
    end

    ch_regif #(.DW(DW), .NCH(NCH)) dut (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wait_o(wait_o),
        .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl), .rx_status(rx_status),
        .tx_status(tx_status), .rx_head(rx_head), .rx_pop(rx_pop),
        .tx_word(tx_word), .tx_push(tx_push), .lbl_wdata(lbl_wdata),
        .lbl_wr(lbl_wr), .lbl_rd(lbl_rd), .lbl_rdata(lbl_rdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .irq(irq)
    );

    function automatic logic [8:0] mk(input int ch, input int tx, input int rs, input int b);
        return {4'(ch), 1'(tx), 2'(rs), 2'(b)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int kind, input int ch, input logic [31:0] v);
        item_t it;
        it.kind = kind; it.chan = ch; it.val = v;
        exp_q.push_back(it);
    endtask

    // kind 0 pop (R8), 1 push (R7), 2 label write (R9), 3 label read (R9)
    always @(negedge clk) begin
        if (!rst && (|{rx_pop, tx_push, lbl_wr, lbl_rd})) begin
            item_t ob, ex;
            logic [NCH-1:0] v;
            ob.val = 32'h0;
            if (|rx_pop)       begin ob.kind = 0; v = rx_pop; end
            else if (|tx_push) begin ob.kind = 1; v = tx_push; ob.val = tx_word; end
            else if (|lbl_wr)  begin ob.kind = 2; v = lbl_wr; ob.val = 32'(lbl_wdata); end
            else               begin ob.kind = 3; v = lbl_rd; end
            ob.chan = -1;
            for (int c = NCH - 1; c >= 0; c--) if (v[c]) ob.chan = c;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R8/R9 unexpected pulse kind %0d chan %0d actual %h expected none",
                         ob.kind, ob.chan, ob.val);
            end else begin
                ex = exp_q.pop_front();
                if (ob.kind != ex.kind || ob.chan != ex.chan || ob.val !== ex.val || $countones(v) != 1) begin
                    errors++;
                    $display("FAIL R7/R8/R9 pulse actual kind %0d chan %0d val %h expected kind %0d chan %0d val %h",
                             ob.kind, ob.chan, ob.val, ex.kind, ex.chan, ex.val);
                end
            end
        end
    end

    task automatic acc(input bit rd, input logic [8:0] a, input logic [7:0] d, input int hold_extra,
                       output logic [7:0] q, output int lat);
        int n;
        @(negedge clk);
        addr = a; wdata = d; rd_n = ~rd; wr_n = rd;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (wait_o && n < 20);
        lat = n - 1;
        q = rdata;
        repeat (1 + hold_extra) @(posedge clk);
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int lat;
        rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0;
        rx_irq = '0; tx_irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R13 rdata at reset", 32'(rdata), 0);
        chk("R13 wait at reset", 32'(wait_o), 0);
        chk("R13 pulses at reset", 32'({rx_pop, tx_push, lbl_wr, lbl_rd}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 control regs after reset", {rx_ctrl, tx_ctrl}, 0);

        // R1 R4: receive control write on channel 1
        acc(0, mk(1, 0, 1, 0), 8'hA5, 0, q, lat);
        chk("R4 write latency", 32'(lat), 2);
        chk("R1 rx_ctrl decode", 32'(rx_ctrl), 32'h0000A500);
        acc(1, mk(1, 0, 1, 0), 8'h00, 0, q, lat);
        chk("R2 ctrl read data", 32'(q), 32'hA5);
        chk("R2 ctrl read latency", 32'(lat), 1);

        // R6 upper lanes of an 8-bit register
        acc(0, mk(1, 0, 1, 1), 8'hFF, 0, q, lat);
        acc(1, mk(1, 0, 1, 1), 8'h00, 0, q, lat);
        chk("R6 upper lane reads zero", 32'(q), 0);
        acc(1, mk(1, 0, 1, 0), 8'h00, 0, q, lat);
        chk("R6 upper lane write ignored", 32'(q), 32'hA5);

        // R1 side bit and status decode
        acc(0, mk(2, 1, 1, 0), 8'h3C, 0, q, lat);
        chk("R1 tx_ctrl decode", 32'(tx_ctrl), 32'h003C0000);
        chk("R1 rx_ctrl untouched by tx write", 32'(rx_ctrl), 32'h0000A500);
        acc(1, mk(3, 1, 2, 0), 8'h00, 0, q, lat);
        chk("R2 tx status read", 32'(q), 32'h23);
        chk("R2 status read latency", 32'(lat), 1);
        acc(1, mk(3, 0, 2, 0), 8'h00, 0, q, lat);
        chk("R1 rx status read", 32'(q), 32'h13);
        acc(0, mk(0, 0, 2, 0), 8'hFF, 0, q, lat);
        acc(1, mk(0, 0, 2, 0), 8'h00, 0, q, lat);
        chk("R10 status write ignored", 32'(q), 32'h10);

        // R3 R8: receive data read lane by lane on channel 2
        for (int k = 0; k < 4; k++) begin
            if (k == 3) push_exp(0, 2, 32'h0);
            acc(1, mk(2, 0, 0, k), 8'h00, 0, q, lat);
            chk("R3 rx data lane", 32'(q), 32'(rx_head[64 + 8*k +: 8]));
            chk("R3 rx data latency", 32'(lat), 6);
        end

        // R12 rdata holds across a write
        acc(0, mk(0, 1, 1, 0), 8'h55, 0, q, lat);
        chk("R12 rdata held over write", 32'(rdata), 32'hA2);

        // R7 transmit staging on channel 1
        for (int k = 0; k < 4; k++) begin
            if (k == 3) push_exp(1, 1, 32'h44332211);
            acc(0, mk(1, 1, 0, k), 8'(8'h11 * (k + 1)), 0, q, lat);
            chk("R7 tx data write latency", 32'(lat), 2);
        end

        // R5 strobe held long after completion: single push only
        for (int k = 0; k < 4; k++) begin
            if (k == 3) push_exp(1, 3, 32'hDDCCBBAA);
            acc(0, mk(3, 1, 0, k), 8'(8'hAA + 8'h11 * k), (k == 3) ? 4 : 0, q, lat);
        end
        chk("R5 wait low after held strobe", 32'(wait_o), 0);

        // R9 label memory
        push_exp(2, 2, 32'h77);
        acc(0, mk(2, 0, 3, 0), 8'h77, 0, q, lat);
        chk("R9 label write latency", 32'(lat), 2);
        push_exp(3, 2, 32'h0);
        acc(1, mk(2, 0, 3, 0), 8'h00, 0, q, lat);
        chk("R9 label read data", 32'(q), 32'h42);
        chk("R3 label read latency", 32'(lat), 6);
        acc(1, mk(2, 0, 3, 1), 8'h00, 0, q, lat);
        chk("R9 label upper lane zero", 32'(q), 0);

        // R10 unused slots and absent channels
        acc(1, mk(0, 1, 3, 0), 8'h00, 0, q, lat);
        chk("R10 unused tx slot reads zero", 32'(q), 0);
        chk("R10 unused slot latency", 32'(lat), 1);
        acc(0, mk(5, 0, 1, 0), 8'h99, 0, q, lat);
        acc(0, mk(5, 1, 1, 0), 8'h99, 0, q, lat);
        chk("R10 absent channel write ignored", {rx_ctrl, tx_ctrl}, {32'h0000A500, 32'h003C0055});
        acc(1, mk(5, 0, 1, 0), 8'h00, 0, q, lat);
        chk("R10 absent channel reads zero", 32'(q), 0);
        acc(1, mk(1, 1, 0, 3), 8'h00, 0, q, lat);
        chk("R10 tx data read zero", 32'(q), 0);
        chk("R10 tx data read latency", 32'(lat), 1);
        acc(0, mk(0, 0, 0, 3), 8'h12, 0, q, lat);
        acc(0, mk(6, 1, 0, 3), 8'h12, 0, q, lat);

        // R11 interrupt OR
        @(negedge clk); rx_irq = 4'b0100;
        @(negedge clk); chk("R11 irq from rx", 32'(irq), 1);
        rx_irq = '0; tx_irq = 4'b1000;
        @(negedge clk); chk("R11 irq from tx", 32'(irq), 1);
        tx_irq = '0;
        @(negedge clk); chk("R11 irq idle", 32'(irq), 0);

        repeat (4) @(negedge clk);
        chk("R7 R8 R9 all expected pulses seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule